// File: doc/BRIEF.md
# Rejection Sampler for Uniform Polynomial Coefficients

This block turns a SHAKE-128 output stream into 256 coefficients that are each uniform below the modulus 3329. On `start` it captures a 34-byte seed, pads it into a single absorb block and asks an external Keccak-f[1600] permutation to process it. Each permuted state supplies one 1344-bit squeeze block, which the block reads as 56 three-byte groups. Every group yields two 12-bit candidates. A candidate is kept only when it is below the modulus. Only after the last group of a block has been read does the block send the whole state back out for the next permutation.

The permutation is reached through two plain pulse ports. A request (`perm_req_valid` with `perm_req_state`) is raised for exactly one cycle. The response (`perm_rsp_valid` with `perm_rsp_state`) may come back any number of cycles later. Accepted coefficients leave on a valid/ready stream. When `coef_valid` is high and `coef_ready` is low, the block stalls: the candidate pointer stays put, and `coef_data` and `coef_last` stay stable until the transfer completes. `coef_valid` never depends on `coef_ready`. The last transfer of a run carries `coef_last`.

Top module: `shk_rej_sampler`

## Requirements
- R1: The first permutation request after `start` carries an absorb state with these bytes (byte k is bits 8k+7..8k): bytes 0..31 hold `rho_i` byte for byte, byte 32 holds `col_j_i`, byte 33 holds `row_i_i`, byte 34 is 0x1F, byte 167 is 0x80, and every other byte of the 200 is zero.
- R2: For a permuted state, group g (0..55) is bytes 3g, 3g+1 and 3g+2, written b0, b1 and b2. The candidates are d1 = b0 + 256*(b1 mod 16) and then d2 = (b1 >> 4) + 16*b2. They are considered in the order group 0 d1, group 0 d2, group 1 d1, and so on.
- R3: A candidate is sent out only when it is strictly less than 3329. A candidate of 3328 is kept and a candidate of 3329 or more is dropped. Every transferred coefficient is below 3329.
- R4: Exactly 256 coefficients are transferred per run. `coef_last` is high with the 256th and with no other. No `coef_valid` appears after it, even when further accepted candidates remain in the same group or block.
- R5: A new permutation request is raised only once all 56 groups of the current block have been read. It carries the full 1600-bit state returned by the previous response, and it is a single-cycle pulse.
- R6: While `coef_valid` is high and `coef_ready` is low, `coef_valid` stays high and `coef_data` stays unchanged on the next cycle.
- R7: `busy` rises the cycle after an accepted `start`. A `start` seen while busy is ignored, and the run continues with the original seed. `busy` is low on the cycle after the 256th transfer.
- R8: After reset, `busy`, `coef_valid` and `perm_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; sampled only while idle |
| rho_i | input | 256 | 32-byte seed, byte 0 in bits 7..0 |
| col_j_i | input | 8 | First index byte appended to the seed |
| row_i_i | input | 8 | Second index byte appended to the seed |
| busy | output | 1 | Run in progress |
| perm_req_valid | output | 1 | One-cycle request to permute `perm_req_state` |
| perm_req_state | output | 1600 | State to be permuted |
| perm_rsp_valid | input | 1 | Permuted state is present |
| perm_rsp_state | input | 1600 | Permuted state |
| coef_valid | output | 1 | Accepted coefficient available |
| coef_ready | input | 1 | Consumer takes the coefficient |
| coef_data | output | 12 | Coefficient value, below 3329 |
| coef_last | output | 1 | Marks the 256th coefficient |

## Verification
The bench replaces the permutation with its own state transforms, so it can shape every squeeze block. One case feeds zero blocks followed by a crafted third block in which the 256th acceptance falls on a d1 whose d2 is also acceptable. A design without the guard on d2 would emit a 257th pulse after `coef_last`. Another case feeds an all-ones block that is wholly rejected. A third feeds a block that alternates 3328 and 3329, so an off-by-one in the comparison shows up as a missing or an extra value. Each request after the first is compared with the previous response and with the number of coefficients consumed, so a design that re-permutes after each group is caught at once. Throttled `coef_ready` and a `start` raised mid-run check for stalls that lose data and for restarts that corrupt the seed.

// File: rtl/shk_rej_pkg.sv
package shk_rej_pkg;
  typedef enum logic [1:0] {
    SM_IDLE = 2'd0,
    SM_REQ  = 2'd1,
    SM_WAIT = 2'd2,
    SM_SCAN = 2'd3
  } smp_state_e;

  localparam int BYTE_W  = 8;
  localparam int GROUP_W = 3 * BYTE_W;
endpackage

// File: rtl/shk_pad_block.sv
module shk_pad_block #(
  parameter int STATE_W    = 1600,
  parameter int RATE_BYTES = 168,
  parameter int RHO_BYTES  = 32
) (
  input  logic [RHO_BYTES*8-1:0] rho,
  input  logic [7:0]             col_j,
  input  logic [7:0]             row_i,
  output logic [STATE_W-1:0]     block
);
  localparam int NBYTES   = STATE_W / 8;
  localparam int J_POS    = RHO_BYTES;
  localparam int I_POS    = RHO_BYTES + 1;
  localparam int SUF_POS  = RHO_BYTES + 2;
  localparam int TAIL_POS = RATE_BYTES - 1;

  // each byte of the absorb block is chosen by its position
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    if (b < RHO_BYTES) begin : g_rho
      assign block[b*8 +: 8] = rho[b*8 +: 8];
    end else if (b == J_POS) begin : g_j
      assign block[b*8 +: 8] = col_j;
    end else if (b == I_POS) begin : g_i
      assign block[b*8 +: 8] = row_i;
    end else if (b == SUF_POS) begin : g_suf
      assign block[b*8 +: 8] = 8'h1F;
    end else if (b == TAIL_POS) begin : g_tail
      assign block[b*8 +: 8] = 8'h80;
    end else begin : g_zero
      assign block[b*8 +: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/shk_group_pick.sv
module shk_group_pick
  import shk_rej_pkg::*;
#(
  parameter int RATE_BYTES = 168,
  parameter int COEF_W     = 12,
  localparam int GROUPS    = RATE_BYTES / 3,
  localparam int GRP_SEL_W = $clog2(GROUPS)
) (
  input  logic [RATE_BYTES*8-1:0] rate,
  input  logic [GRP_SEL_W-1:0]    grp,
  input  logic                    second,
  output logic [COEF_W-1:0]       cand
);
  logic [GROUP_W-1:0] words [GROUPS];
  logic [GROUP_W-1:0] word;
  logic [7:0]         b0, b1, b2;

  for (genvar g = 0; g < GROUPS; g++) begin : g_words
    assign words[g] = rate[g*GROUP_W +: GROUP_W];
  end

  always_comb begin
    word = '0;
    if (int'(grp) < GROUPS) word = words[grp];
  end

  assign b0 = word[7:0];
  assign b1 = word[15:8];
  assign b2 = word[23:16];

  // first candidate: low byte plus low nibble; second: high nibble plus top byte
  assign cand = second ? {b2, b1[7:4]} : {b1[3:0], b0};
endmodule

// File: rtl/shk_rej_ctrl.sv
module shk_rej_ctrl
  import shk_rej_pkg::*;
#(
  parameter int NCOEF     = 256,
  parameter int Q         = 3329,
  parameter int COEF_W    = 12,
  parameter int GROUPS    = 56,
  localparam int CNT_W    = $clog2(NCOEF + 1),
  localparam int GRP_SEL_W = $clog2(GROUPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 perm_rsp_valid,
  input  logic [COEF_W-1:0]    cand,
  input  logic                 coef_ready,
  output logic                 busy,
  output logic                 cap_seed,
  output logic                 load_state,
  output logic                 absorb,
  output logic                 perm_req_valid,
  output logic [GRP_SEL_W-1:0] grp,
  output logic                 second,
  output logic                 coef_valid,
  output logic                 coef_last
);
  localparam logic [COEF_W-1:0]    Q_C      = COEF_W'(Q);
  localparam logic [CNT_W-1:0]     LAST_CNT = CNT_W'(NCOEF - 1);
  localparam logic [CNT_W-1:0]     FULL_CNT = CNT_W'(NCOEF);
  localparam logic [GRP_SEL_W-1:0] LAST_GRP = GRP_SEL_W'(GROUPS - 1);

  smp_state_e     st;
  logic [CNT_W-1:0] cnt;
  logic           need_more, accept, step, final_xfer;

  assign need_more  = (cnt < FULL_CNT);
  assign accept     = (cand < Q_C);
  assign coef_valid = (st == SM_SCAN) && accept && need_more;
  assign coef_last  = coef_valid && (cnt == LAST_CNT);
  assign step       = (st == SM_SCAN) && (!coef_valid || coef_ready);
  assign final_xfer = coef_valid && coef_ready && (cnt == LAST_CNT);

  assign busy           = (st != SM_IDLE);
  assign cap_seed       = (st == SM_IDLE) && start;
  assign perm_req_valid = (st == SM_REQ);
  assign load_state     = (st == SM_WAIT) && perm_rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SM_IDLE;
      cnt    <= '0;
      grp    <= '0;
      second <= 1'b0;
      absorb <= 1'b0;
    end else begin
      unique case (st)
        SM_IDLE: if (start) begin
          st     <= SM_REQ;
          cnt    <= '0;
          grp    <= '0;
          second <= 1'b0;
          absorb <= 1'b1;
        end
        SM_REQ: st <= SM_WAIT;
        SM_WAIT: if (perm_rsp_valid) begin
          st     <= SM_SCAN;
          absorb <= 1'b0;
          grp    <= '0;
          second <= 1'b0;
        end
        SM_SCAN: if (step) begin
          if (coef_valid) cnt <= cnt + 1'b1;
          if (final_xfer) begin
            st <= SM_IDLE;
          end else if (second && grp == LAST_GRP) begin
            st     <= SM_REQ;
            grp    <= '0;
            second <= 1'b0;
          end else if (second) begin
            grp    <= grp + 1'b1;
            second <= 1'b0;
          end else begin
            second <= 1'b1;
          end
        end
        default: st <= SM_IDLE;
      endcase
    end
  end

  assert_coef_below_q_R3: assert property (@(posedge clk) disable iff (!rst_n)
    coef_valid |-> (cand < Q_C));
  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid && !coef_ready) |=> (coef_valid && $stable(cand)));
  assert_last_has_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    coef_last |-> coef_valid);
  assert_idle_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid && coef_ready && coef_last) |=> !busy);
  assert_req_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    perm_req_valid |=> !perm_req_valid);
  assert_no_valid_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !coef_valid);
endmodule

// File: rtl/shk_rej_sampler.sv
module shk_rej_sampler
  import shk_rej_pkg::*;
#(
  parameter int STATE_W    = 1600,
  parameter int RATE_BYTES = 168,
  parameter int RHO_BYTES  = 32,
  parameter int NCOEF      = 256,
  parameter int Q          = 3329,
  parameter int COEF_W     = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [RHO_BYTES*8-1:0] rho_i,
  input  logic [7:0]             col_j_i,
  input  logic [7:0]             row_i_i,
  output logic                   busy,
  output logic                   perm_req_valid,
  output logic [STATE_W-1:0]     perm_req_state,
  input  logic                   perm_rsp_valid,
  input  logic [STATE_W-1:0]     perm_rsp_state,
  output logic                   coef_valid,
  input  logic                   coef_ready,
  output logic [COEF_W-1:0]      coef_data,
  output logic                   coef_last
);
  localparam int RATE_W    = RATE_BYTES * 8;
  localparam int GROUPS    = RATE_BYTES / 3;
  localparam int GRP_SEL_W = $clog2(GROUPS);

  logic [RHO_BYTES*8-1:0] rho_q;
  logic [7:0]             col_q, row_q;
  logic [STATE_W-1:0]     st_q, pad_blk;
  logic                   cap_seed, load_state, absorb, second;
  logic [GRP_SEL_W-1:0]   grp;
  logic [COEF_W-1:0]      cand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rho_q <= '0;
      col_q <= '0;
      row_q <= '0;
      st_q  <= '0;
    end else begin
      if (cap_seed) begin
        rho_q <= rho_i;
        col_q <= col_j_i;
        row_q <= row_i_i;
      end
      if (load_state) st_q <= perm_rsp_state;
    end
  end

  shk_pad_block #(
    .STATE_W(STATE_W), .RATE_BYTES(RATE_BYTES), .RHO_BYTES(RHO_BYTES)
  ) u_pad (
    .rho(rho_q), .col_j(col_q), .row_i(row_q), .block(pad_blk)
  );

  shk_group_pick #(
    .RATE_BYTES(RATE_BYTES), .COEF_W(COEF_W)
  ) u_pick (
    .rate(st_q[RATE_W-1:0]), .grp(grp), .second(second), .cand(cand)
  );

  shk_rej_ctrl #(
    .NCOEF(NCOEF), .Q(Q), .COEF_W(COEF_W), .GROUPS(GROUPS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .perm_rsp_valid(perm_rsp_valid),
    .cand(cand), .coef_ready(coef_ready), .busy(busy), .cap_seed(cap_seed),
    .load_state(load_state), .absorb(absorb), .perm_req_valid(perm_req_valid),
    .grp(grp), .second(second), .coef_valid(coef_valid), .coef_last(coef_last)
  );

  // the absorb block goes out on the first request; later requests reuse the held state
  assign perm_req_state = absorb ? pad_blk : st_q;
  assign coef_data      = cand;

  assert_seed_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(rho_q) && $stable(col_q) && $stable(row_q)));
  assert_state_held_in_scan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !perm_rsp_valid) |=> $stable(st_q));
endmodule

// File: tb/shk_rej_sampler_tb_top.sv
`timescale 1ns/1ps
module shk_rej_sampler_tb_top;
  localparam int SW = 1600;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [255:0]  rho_i = '0;
  logic [7:0]    col_j_i = '0, row_i_i = '0;
  logic          busy, perm_req_valid, perm_rsp_valid = 1'b0;
  logic [SW-1:0] perm_req_state, perm_rsp_state = '0;
  logic          coef_valid, coef_ready = 1'b0, coef_last;
  logic [11:0]   coef_data;

  int checks = 0, fails = 0;
  int exp_coef [0:255];
  int qlen;

  always #2.5 clk = ~clk;

  shk_rej_sampler dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rho_i(rho_i), .col_j_i(col_j_i),
    .row_i_i(row_i_i), .busy(busy), .perm_req_valid(perm_req_valid),
    .perm_req_state(perm_req_state), .perm_rsp_valid(perm_rsp_valid),
    .perm_rsp_state(perm_rsp_state), .coef_valid(coef_valid), .coef_ready(coef_ready),
    .coef_data(coef_data), .coef_last(coef_last)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] pad_model(input logic [255:0] rho, input logic [7:0] j,
                                               input logic [7:0] i);
    logic [SW-1:0] s = '0;
    for (int k = 0; k < 32; k++) s[8*k +: 8] = rho[8*k +: 8];
    s[8*32 +: 8]  = j;
    s[8*33 +: 8]  = i;
    s[8*34 +: 8]  = 8'h1F;
    s[8*167 +: 8] = 8'h80;
    return s;
  endfunction

  function automatic logic [SW-1:0] pmix(input logic [SW-1:0] x, input int salt);
    logic [SW-1:0] y;
    logic [63:0] lane, nb;
    for (int k = 0; k < 25; k++) begin
      lane = x[64*k +: 64];
      nb   = x[64*((k+7)%25) +: 64];
      y[64*k +: 64] = {lane[50:0], lane[63:51]} ^ nb ^ (64'h9E3779B97F4A7C15 * 64'(k + salt + 1));
    end
    return y;
  endfunction

  function automatic logic [SW-1:0] make_rsp(input int mode, input int blk, input logic [SW-1:0] req);
    logic [SW-1:0] s = '0;
    case (mode)
      1: if (blk >= 2) s[23:0] = 24'h000FFF;        // bytes FF,0F,00: d1=4095 rejected, d2=0
      2: s = (blk == 0) ? {SW{1'b1}} : pmix(req, blk);
      3: if (blk == 0) begin
           for (int g = 0; g < 56; g++) s[24*g +: 24] = 24'hD01D00; // d1=3328, d2=3329
         end else s = pmix(req, blk);
      default: s = pmix(req, blk);
    endcase
    return s;
  endfunction

  task automatic expand(input logic [SW-1:0] s);
    int b0, b1, b2, d1, d2;
    for (int g = 0; g < 56; g++) begin
      b0 = int'(s[24*g +: 8]); b1 = int'(s[24*g+8 +: 8]); b2 = int'(s[24*g+16 +: 8]);
      d1 = b0 + 256 * (b1 % 16);
      d2 = (b1 >> 4) + 16 * b2;
      if (d1 < 3329 && qlen < 256) begin exp_coef[qlen] = d1; qlen++; end
      if (d2 < 3329 && qlen < 256) begin exp_coef[qlen] = d2; qlen++; end
    end
  endtask

  function automatic int first_diff(input logic [SW-1:0] a, input logic [SW-1:0] b);
    for (int k = 0; k < SW/8; k++) if (a[8*k +: 8] !== b[8*k +: 8]) return k;
    return -1;
  endfunction

  task automatic run_case(input string name, input int mode, input bit stall, input bit poke,
                          input logic [255:0] rho, input logic [7:0] j, input logic [7:0] i);
    logic [SW-1:0] rsp_hold, model, expst;
    int blk, pend, idx, cyc, fd, quiet_bad;
    bit first, held_v;
    logic [11:0] held_d;
    qlen = 0; blk = 0; pend = 0; idx = 0; cyc = 0; first = 1; held_v = 0;
    model = '0; rsp_hold = '0;
    $display("case %s", name);
    @(negedge clk);
    rho_i = rho; col_j_i = j; row_i_i = i; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R7 busy after start", longint'(busy), 1);
    while (idx < 256 && cyc < 20000) begin
      perm_rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          perm_rsp_valid = 1'b1;
          perm_rsp_state = rsp_hold;
          expand(rsp_hold);
        end
      end
      if (perm_req_valid) begin
        expst = first ? pad_model(rho, j, i) : model;
        fd = first_diff(perm_req_state, expst);
        chk(fd < 0, first ? "R1 absorb block byte" : "R5 request state byte",
            (fd < 0) ? 0 : longint'(perm_req_state[8*fd +: 8]),
            (fd < 0) ? 0 : longint'(expst[8*fd +: 8]));
        if (!first) chk(idx == qlen, "R5 request only after block used", idx, qlen);
        first = 0;
        rsp_hold = make_rsp(mode, blk, perm_req_state);
        model = rsp_hold;
        blk++;
        pend = 3;
      end
      if (held_v) begin
        chk(coef_valid === 1'b1, "R6 valid held", longint'(coef_valid), 1);
        chk(coef_data === held_d, "R6 data held", longint'(coef_data), longint'(held_d));
      end
      coef_ready = stall ? ((cyc % 4) == 3) : 1'b1;
      held_v = 0;
      if (coef_valid === 1'b1) begin
        if (coef_ready) begin
          chk(int'(coef_data) == exp_coef[idx] && idx < qlen, "R2 R3 coefficient value",
              longint'(coef_data), exp_coef[idx]);
          chk(coef_last === (idx == 255), "R4 last flag", longint'(coef_last), (idx == 255));
          idx++;
        end else begin
          held_v = 1; held_d = coef_data;
        end
      end
      if (poke && cyc == 30) begin
        start = 1'b1; rho_i = ~rho; col_j_i = ~j;
      end else start = 1'b0;
      cyc++;
      @(negedge clk);
    end
    perm_rsp_valid = 1'b0;
    start = 1'b0;
    chk(idx == 256, "R4 coefficient count", idx, 256);
    chk(busy === 1'b0, "R7 idle one cycle after last", longint'(busy), 0);
    quiet_bad = 0;
    for (int k = 0; k < 16; k++) begin
      if (coef_valid !== 1'b0 || perm_req_valid !== 1'b0) quiet_bad++;
      @(negedge clk);
    end
    chk(quiet_bad == 0, "R4 no pulse after last", quiet_bad, 0);
  endtask

  task automatic test_reset;
    chk(busy === 1'b0, "R8 busy at reset", longint'(busy), 0);
    chk(coef_valid === 1'b0, "R8 coef_valid at reset", longint'(coef_valid), 0);
    chk(perm_req_valid === 1'b0, "R8 request at reset", longint'(perm_req_valid), 0);
  endtask

  task automatic test_mixed;
    run_case("mixed blocks", 0, 0, 0, {8{32'h0123ABCD}}, 8'h00, 8'h01);
  endtask

  task automatic test_guard_d2;
    run_case("256th on d1 with d2 acceptable", 1, 0, 0, {8{32'h5A5A5A5A}}, 8'h02, 8'h03);
  endtask

  task automatic test_reject_block;
    run_case("fully rejected block", 2, 0, 0, {8{32'hFEDC1234}}, 8'h01, 8'h00);
  endtask

  task automatic test_bound;
    run_case("3328 kept 3329 dropped", 3, 0, 0, {8{32'h13579BDF}}, 8'h03, 8'h02);
  endtask

  task automatic test_stall_poke;
    run_case("stalled consumer, start while busy", 0, 1, 1, {8{32'hCAFE0042}}, 8'h07, 8'h05);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_mixed();
    test_guard_d2();
    test_reject_block();
    test_bound();
    test_stall_poke();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule